// File: doc/BRIEF.md
# Signed Binary to BCD Converter

The block turns a 12-bit two's complement word into a sign flag and four decimal digits (thousands, hundreds, tens, units), each a 4-bit BCD code. A mode input picks the source word: the switch word when high, the sensor word when low. A start pulse latches the chosen word. The block then splits off the sign, forms the magnitude, and converts it one bit per clock with the shift-and-add-3 method. A single-cycle done pulse marks the result.

The digit and sign outputs keep their last result while a new conversion runs, and change only on the cycle that done is high. This lets a display scanner read them at any time without tearing. A start that arrives while a conversion is running is dropped. Segment decoding and display scanning are handled elsewhere.

Top module: `signed_bcd_conv`

## Requirements
- R1: The block converts `sw_word_i` when `mode_i` is high and `sens_word_i` when `mode_i` is low, in both cases the value on that input at the clock edge that accepts start.
- R2: `neg_o` is bit 11 of the accepted word: 1 for negative, 0 for zero or positive.
- R3: The digits give the decimal absolute value of the accepted word, over the full range 0 to 2048; for example, -2048 gives 2,0,4,8.
- R4: `thou_o`, `hund_o`, `tens_o` and `units_o` each hold a BCD code for their decimal place, in the range 0 to 9.
- R5: `done_o` goes high exactly 12 rising clock edges after the edge that accepts start, and it stays high for one cycle only.
- R6: The digits and `neg_o` change only in the cycle when `done_o` is high; at all other times they hold their value.
- R7: While `busy_o` is high, `start_i` is ignored. The current result is not changed, and the end of the current conversion is not delayed.
- R8: When `rst_ni` is low, all digits, `neg_o`, `busy_o` and `done_o` are forced to 0.
- R9: `busy_o` rises only on an edge where `start_i` was high. It stays high from the accepting edge until the edge that raises `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Source select: 1 selects the switch word, 0 selects the sensor word |
| sw_word_i | input | 12 | Switch-supplied two's complement word |
| sens_word_i | input | 12 | Sensor-supplied two's complement word |
| start_i | input | 1 | Start request, sampled while idle |
| thou_o | output | 4 | Thousands BCD digit |
| hund_o | output | 4 | Hundreds BCD digit |
| tens_o | output | 4 | Tens BCD digit |
| units_o | output | 4 | Units BCD digit |
| neg_o | output | 1 | Sign of the last result |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle result strobe |

## Verification
A missed or extra add-3 in any column appears as a wrong or non-BCD digit on the next done pulse. Such errors show most readily in values with many carries, such as 999, 2047 and -2048. An iteration counter that is off by one moves `done_o` away from the 12-edge mark and scales the result by two, so one conversion exposes it. Corrupt sign or magnitude handling shows on -1 and -2048. A busy flag that does not hold shows as a second start that changes the pending result or the latency, which the bench checks in the same conversion.

// File: rtl/sbcd_pkg.sv
package sbcd_pkg;
  localparam int unsigned DIG_W = 4;

  // add-3 pre-adjust for one BCD column
  function automatic logic [DIG_W-1:0] col_adj(input logic [DIG_W-1:0] c);
    return (c > 4'd4) ? c + 4'd3 : c;
  endfunction
endpackage

// File: rtl/sbcd_sign_mag.sv
module sbcd_sign_mag #(
  parameter int unsigned W = 12
) (
  input  logic         mode_i,
  input  logic [W-1:0] sw_i,
  input  logic [W-1:0] sens_i,
  output logic         neg_o,
  output logic [W-1:0] mag_o
);
  logic [W-1:0] word;

  assign word  = mode_i ? sw_i : sens_i;
  assign neg_o = word[W-1];
  // most negative value wraps to itself: correct unsigned magnitude
  assign mag_o = neg_o ? (~word + 1'b1) : word;
endmodule

// File: rtl/sbcd_dabble.sv
module sbcd_dabble
  import sbcd_pkg::*;
#(
  parameter int unsigned BIN_W = 12,
  parameter int unsigned N_DIG = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   load_i,
  input  logic [BIN_W-1:0]       mag_i,
  output logic                   busy_o,
  output logic                   last_o,
  output logic [N_DIG*DIG_W-1:0] bcd_nxt_o
);
  localparam int unsigned BCD_W = N_DIG * DIG_W;
  localparam int unsigned CNT_W = $clog2(BIN_W + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BIN_W - 1);

  logic [BCD_W-1:0] bcd_q, bcd_adj;
  logic [BIN_W-1:0] bin_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  for (genvar d = 0; d < N_DIG; d++) begin : g_col
    assign bcd_adj[d*DIG_W +: DIG_W] = col_adj(bcd_q[d*DIG_W +: DIG_W]);
  end

  assign bcd_nxt_o = {bcd_adj[BCD_W-2:0], bin_q[BIN_W-1]};
  assign last_o    = busy_q && (cnt_q == LAST_CNT);
  assign busy_o    = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bcd_q  <= '0;
      bin_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (load_i) begin
      bcd_q  <= '0;
      bin_q  <= mag_i;
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      bcd_q  <= bcd_nxt_o;
      bin_q  <= {bin_q[BIN_W-2:0], 1'b0};
      cnt_q  <= cnt_q + 1'b1;
      busy_q <= !last_o;
    end
  end

  a_r9_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q <= LAST_CNT));
  a_r7_load_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !last_o |=> busy_q && cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/signed_bcd_conv.sv
module signed_bcd_conv
  import sbcd_pkg::*;
#(
  parameter int unsigned IN_W  = 12,
  parameter int unsigned N_DIG = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            mode_i,
  input  logic [IN_W-1:0] sw_word_i,
  input  logic [IN_W-1:0] sens_word_i,
  input  logic            start_i,
  output logic [3:0]      thou_o,
  output logic [3:0]      hund_o,
  output logic [3:0]      tens_o,
  output logic [3:0]      units_o,
  output logic            neg_o,
  output logic            busy_o,
  output logic            done_o
);
  localparam int unsigned BCD_W = N_DIG * DIG_W;

  logic             sel_neg, accept, last, busy;
  logic [IN_W-1:0]  sel_mag;
  logic [BCD_W-1:0] bcd_nxt, dig_q;
  logic             neg_pend_q, neg_q, done_q;

  assign accept = start_i && !busy;

  sbcd_sign_mag #(.W(IN_W)) u_sm (
    .mode_i (mode_i),
    .sw_i   (sw_word_i),
    .sens_i (sens_word_i),
    .neg_o  (sel_neg),
    .mag_o  (sel_mag)
  );

  sbcd_dabble #(.BIN_W(IN_W), .N_DIG(N_DIG)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (accept),
    .mag_i     (sel_mag),
    .busy_o    (busy),
    .last_o    (last),
    .bcd_nxt_o (bcd_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dig_q      <= '0;
      neg_pend_q <= 1'b0;
      neg_q      <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      done_q <= last;
      if (accept) neg_pend_q <= sel_neg;
      if (last) begin
        dig_q <= bcd_nxt;
        neg_q <= neg_pend_q;
      end
    end
  end

  assign units_o = dig_q[3:0];
  assign tens_o  = dig_q[7:4];
  assign hund_o  = dig_q[11:8];
  assign thou_o  = dig_q[15:12];
  assign neg_o   = neg_q;
  assign busy_o  = busy;
  assign done_o  = done_q;

  a_r5_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r9_done_ends_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o));
  a_r9_busy_from_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(dig_q) && $stable(neg_o));
  a_r4_bcd_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> thou_o <= 4'd9 && hund_o <= 4'd9 && tens_o <= 4'd9 && units_o <= 4'd9);
endmodule

// File: tb/sim_signed_bcd_conv.sv
`timescale 1ns/1ps
module sim_signed_bcd_conv;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mode = 1'b1, start = 1'b0;
  logic [11:0] sw = '0, sens = '0;
  logic [3:0]  thou, hund, tens, units;
  logic        neg, busy, done;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  signed_bcd_conv u0 (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode), .sw_word_i(sw),
    .sens_word_i(sens), .start_i(start), .thou_o(thou), .hund_o(hund),
    .tens_o(tens), .units_o(units), .neg_o(neg), .busy_o(busy), .done_o(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int dec_of(input logic [11:0] w);
    int s = $signed(w);
    return (s < 0) ? -s : s;
  endfunction

  function automatic int dig_val();
    return thou * 1000 + hund * 100 + tens * 10 + units;
  endfunction

  // pulse start, optionally inject a second start mid-run, check everything
  task automatic run_conv(input string req, input logic m, input logic [11:0] s_w,
                          input logic [11:0] s_s, input bit inject);
    logic [11:0] w = m ? s_w : s_s;
    int exp = dec_of(w);
    int lat = 0;
    int old_v = dig_val();
    int old_n = neg;
    @(negedge clk);
    mode = m; sw = s_w; sens = s_s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    sw = ~s_w; sens = ~s_s; mode = ~m; // input changes after acceptance must not matter (R1)
    chk({req, " R9 busy"}, busy, 1);
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
      if (!done) chk({req, " R6 hold"}, dig_val() * 2 + 0, old_v * 2 + 0 + (neg != old_n));
      if (inject && lat == 4) start = 1'b1;   // R7 start while busy
      if (inject && lat == 6) start = 1'b0;
    end
    start = 1'b0;
    chk({req, " R5 latency"}, lat, 12);
    chk({req, " R3 value"}, dig_val(), exp);
    chk({req, " R2 sign"}, neg, w[11]);
    chk({req, " R4 range"}, int'(thou <= 9 && hund <= 9 && tens <= 9 && units <= 9), 1);
    @(negedge clk);
    chk({req, " R5 pulse"}, done, 0);
    chk({req, " R9 idle"}, busy, 0);
  endtask

  task automatic t_reset();
    chk("R8 digits", dig_val(), 0);
    chk("R8 sign", neg, 0);
    chk("R8 busy", busy, 0);
    chk("R8 done", done, 0);
  endtask

  task automatic t_reset_mid();
    @(negedge clk);
    sw = 12'h800; mode = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    repeat (20) @(negedge clk);
    chk("R8 no late done", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    run_conv("zero R3",      1'b1, 12'd0,    12'd5,    1'b0);
    run_conv("max R3",       1'b1, 12'd2047, 12'd0,    1'b0);
    run_conv("min R3",       1'b1, 12'h800,  12'd1,    1'b0);
    run_conv("minus1 R2",    1'b1, 12'hFFF,  12'd0,    1'b0);
    run_conv("999 R4",       1'b1, 12'd999,  12'd0,    1'b0);
    run_conv("sens R1",      1'b0, 12'd123,  -12'sd1000, 1'b0);
    run_conv("sw R1",        1'b1, 12'd1000, 12'd77,   1'b0);
    run_conv("busy R7",      1'b1, 12'd1234, 12'd0,    1'b1);
    run_conv("neg R2",       1'b0, 12'd0,    -12'sd305, 1'b0);
    t_reset_mid();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule